// File: doc/BRIEF.md
# Registered Half-Word Bus Exchanger

This block links one narrow data port (A) with two narrow storage ports (B1 and B2). Together, B1 and B2 form a double-width bus. Going from A to B, each B side has its own capture register, gated by its own active-low capture enable. A caller can therefore place one A word into B1 on one clock and the following A word into B2 on a later clock. Both halves then appear together as one wide word.

Going from B to A, a single register loads on every rising clock edge. A select input decides whether that register takes the word on the B1 input or the word on the B2 input.

Each port has its own active-low output-enable input. These enables are registered, so a port's drive flag changes only at a rising edge. Every port is modelled as a data output plus an active-high drive flag; a drive flag of 0 stands for high impedance. A synchronous active-high reset clears all data registers to zero and turns every drive flag off.

Top module: `reg_bus_exchanger`

## Requirements
- R1: On a rising edge with `rst` low and `cap1_n` low, `b1_out` takes the value of `a_in` sampled at that edge.
- R2: On a rising edge with `rst` low and `cap2_n` low, `b2_out` takes the value of `a_in` sampled at that edge.
- R3: While a capture enable is high at an edge, its B register keeps its contents, whatever `a_in` carries.
- R4: Two successive A words, the first captured with `cap1_n` low and the second with `cap2_n` low, are then both present, one on `b1_out` and one on `b2_out`, as one wide word.
- R5: With `rst` low, `a_out` loads at every rising edge. It takes `b1_in` when `pick_b1` is 1 at that edge and `b2_in` when it is 0.
- R6: Each output enable is active low and registered. A drive flag becomes 1 at the first rising edge at which its enable input is sampled low. It becomes 0 at the first edge at which that enable input is sampled high. Between edges the flag does not follow the input.
- R7: `oe_a_n` controls only `a_drive`, `oe_b1_n` controls only `b1_drive`, and `oe_b2_n` controls only `b2_drive`.
- R8: A rising edge with `rst` high sets `a_out`, `b1_out` and `b2_out` to zero and all three drive flags to 0. While `rst` stays high, the capture enables and the output enables have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rst | input | 1 | Synchronous reset, active high |
| a_in | input | W | Word arriving on the A port |
| a_out | output | W | A-side return register |
| a_drive | output | 1 | A port drives when 1, high impedance when 0 |
| b1_in | input | W | Word arriving on the B1 port |
| b1_out | output | W | B1 capture register |
| b1_drive | output | 1 | B1 port drives when 1 |
| b2_in | input | W | Word arriving on the B2 port |
| b2_out | output | W | B2 capture register |
| b2_drive | output | 1 | B2 port drives when 1 |
| cap1_n | input | 1 | Active-low capture enable for B1 |
| cap2_n | input | 1 | Active-low capture enable for B2 |
| pick_b1 | input | 1 | 1 returns B1 to A, 0 returns B2 to A |
| oe_a_n | input | 1 | Active-low output enable for A |
| oe_b1_n | input | 1 | Active-low output enable for B1 |
| oe_b2_n | input | 1 | Active-low output enable for B2 |

## Verification
Every result of this block sits exactly one register away from its inputs. B captures, A returns and drive flags all change at the first rising edge after the stimulus is set up, and at no other time. The bench changes inputs 1 ns after an edge and samples outputs 1 ns after the next edge, so each check lands in the cycle that follows its stimulus. For the drive flags, it also samples once before that edge, to show the flag has not yet moved.

// File: rtl/bx_pkg.sv
package bx_pkg;

    // Number of B-side halves that make up the wide word.
    localparam int BX_HALVES = 2;

    // One drive flag per port; 1 means the port drives.
    typedef struct packed {
        logic a;
        logic b1;
        logic b2;
    } bx_drive_t;

endpackage

// File: rtl/bx_bank.sv
// One B-side capture register with an active-low capture enable.
module bx_bank #(
    parameter int W = 12
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         cap_n,
    input  logic [W-1:0] din,
    output logic [W-1:0] word
);

    typedef struct packed {
        logic [W-1:0] word;
    } bank_t;

    bank_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (rst) begin
            st_d.word = '0;
        end else if (!cap_n) begin
            st_d.word = din;
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign word = st_q.word;

endmodule

// File: rtl/bx_return.sv
// Single A-side register, loaded every edge from the selected B input.
module bx_return #(
    parameter int W = 12
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         pick_b1,
    input  logic [W-1:0] b1_in,
    input  logic [W-1:0] b2_in,
    output logic [W-1:0] word
);

    typedef struct packed {
        logic [W-1:0] word;
    } ret_t;

    ret_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (rst) begin
            st_d.word = '0;
        end else begin
            st_d.word = pick_b1 ? b1_in : b2_in;
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign word = st_q.word;

endmodule

// File: rtl/bx_drive.sv
// Registered output enables, converted to active-high drive flags.
module bx_drive
    import bx_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      oe_a_n,
    input  logic      oe_b1_n,
    input  logic      oe_b2_n,
    output bx_drive_t drive
);

    bx_drive_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (rst) begin
            st_d = '0;
        end else begin
            st_d.a  = ~oe_a_n;
            st_d.b1 = ~oe_b1_n;
            st_d.b2 = ~oe_b2_n;
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign drive = st_q;

endmodule

// File: rtl/reg_bus_exchanger.sv
module reg_bus_exchanger
    import bx_pkg::*;
#(
    parameter int W = 12
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] a_in,
    output logic [W-1:0] a_out,
    output logic         a_drive,
    input  logic [W-1:0] b1_in,
    output logic [W-1:0] b1_out,
    output logic         b1_drive,
    input  logic [W-1:0] b2_in,
    output logic [W-1:0] b2_out,
    output logic         b2_drive,
    input  logic         cap1_n,
    input  logic         cap2_n,
    input  logic         pick_b1,
    input  logic         oe_a_n,
    input  logic         oe_b1_n,
    input  logic         oe_b2_n
);

    localparam int HW = BX_HALVES;

    logic [HW-1:0]         cap_n_vec;
    logic [HW-1:0][W-1:0]  bank_q;
    bx_drive_t             drive;

    assign cap_n_vec = {cap2_n, cap1_n};

    for (genvar g = 0; g < HW; g++) begin : g_half
        bx_bank #(.W(W)) u_bank (
            .clk   (clk),
            .rst   (rst),
            .cap_n (cap_n_vec[g]),
            .din   (a_in),
            .word  (bank_q[g])
        );
    end

    bx_return #(.W(W)) u_return (
        .clk     (clk),
        .rst     (rst),
        .pick_b1 (pick_b1),
        .b1_in   (b1_in),
        .b2_in   (b2_in),
        .word    (a_out)
    );

    bx_drive u_drive (
        .clk     (clk),
        .rst     (rst),
        .oe_a_n  (oe_a_n),
        .oe_b1_n (oe_b1_n),
        .oe_b2_n (oe_b2_n),
        .drive   (drive)
    );

    assign b1_out   = bank_q[0];
    assign b2_out   = bank_q[1];
    assign a_drive  = drive.a;
    assign b1_drive = drive.b1;
    assign b2_drive = drive.b2;

endmodule

// File: rtl/bx_checker.sv
module bx_checker #(
    parameter int W = 12
) (
    input logic         clk,
    input logic         rst,
    input logic [W-1:0] a_in,
    input logic [W-1:0] a_out,
    input logic         a_drive,
    input logic [W-1:0] b1_in,
    input logic [W-1:0] b1_out,
    input logic         b1_drive,
    input logic [W-1:0] b2_in,
    input logic [W-1:0] b2_out,
    input logic         b2_drive,
    input logic         cap1_n,
    input logic         cap2_n,
    input logic         pick_b1,
    input logic         oe_a_n,
    input logic         oe_b1_n,
    input logic         oe_b2_n
);

    assert_load_b1_R1: assert property (@(posedge clk) disable iff (rst)
        !cap1_n |=> b1_out == $past(a_in));

    assert_load_b2_R2: assert property (@(posedge clk) disable iff (rst)
        !cap2_n |=> b2_out == $past(a_in));

    assert_hold_b1_R3: assert property (@(posedge clk) disable iff (rst)
        cap1_n |=> $stable(b1_out));

    assert_hold_b2_R3: assert property (@(posedge clk) disable iff (rst)
        cap2_n |=> $stable(b2_out));

    assert_ret_b1_R5: assert property (@(posedge clk) disable iff (rst)
        pick_b1 |=> a_out == $past(b1_in));

    assert_ret_b2_R5: assert property (@(posedge clk) disable iff (rst)
        !pick_b1 |=> a_out == $past(b2_in));

    assert_drive_a_R6: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> a_drive == !$past(oe_a_n));

    assert_drive_b1_R7: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> b1_drive == !$past(oe_b1_n));

    assert_drive_b2_R7: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> b2_drive == !$past(oe_b2_n));

    assert_reset_state_R8: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> (!a_drive && !b1_drive && !b2_drive &&
                        a_out == '0 && b1_out == '0 && b2_out == '0));

endmodule

bind reg_bus_exchanger bx_checker #(.W(W)) u_bx_checker (
    .clk      (clk),
    .rst      (rst),
    .a_in     (a_in),
    .a_out    (a_out),
    .a_drive  (a_drive),
    .b1_in    (b1_in),
    .b1_out   (b1_out),
    .b1_drive (b1_drive),
    .b2_in    (b2_in),
    .b2_out   (b2_out),
    .b2_drive (b2_drive),
    .cap1_n   (cap1_n),
    .cap2_n   (cap2_n),
    .pick_b1  (pick_b1),
    .oe_a_n   (oe_a_n),
    .oe_b1_n  (oe_b1_n),
    .oe_b2_n  (oe_b2_n)
);

// File: tb/tb_reg_bus_exchanger.sv
module tb_reg_bus_exchanger;

    localparam int W = 12;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic [W-1:0] a_in = '0, b1_in = '0, b2_in = '0;
    logic [W-1:0] a_out, b1_out, b2_out;
    logic         a_drive, b1_drive, b2_drive;
    logic         cap1_n = 1'b1, cap2_n = 1'b1, pick_b1 = 1'b0;
    logic         oe_a_n = 1'b1, oe_b1_n = 1'b1, oe_b2_n = 1'b1;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    reg_bus_exchanger #(.W(W)) dut (
        .clk(clk), .rst(rst),
        .a_in(a_in), .a_out(a_out), .a_drive(a_drive),
        .b1_in(b1_in), .b1_out(b1_out), .b1_drive(b1_drive),
        .b2_in(b2_in), .b2_out(b2_out), .b2_drive(b2_drive),
        .cap1_n(cap1_n), .cap2_n(cap2_n), .pick_b1(pick_b1),
        .oe_a_n(oe_a_n), .oe_b1_n(oe_b1_n), .oe_b2_n(oe_b2_n)
    );

    typedef struct packed {
        logic         c1n;
        logic         c2n;
        logic [W-1:0] a;
        logic [W-1:0] b1;
        logic [W-1:0] b2;
        logic         sel;
        logic [W-1:0] exp_b1;
        logic [W-1:0] exp_b2;
        logic [W-1:0] exp_a;
    } vec_t;

    // Walk starts from the all-zero reset state.
    localparam vec_t TBL [8] = '{
        '{1'b0, 1'b1, 12'h123, 12'hAAA, 12'h555, 1'b1, 12'h123, 12'h000, 12'hAAA},
        '{1'b1, 1'b0, 12'h456, 12'hAAA, 12'h555, 1'b0, 12'h123, 12'h456, 12'h555},
        '{1'b1, 1'b1, 12'hFFF, 12'h0F0, 12'hF0F, 1'b1, 12'h123, 12'h456, 12'h0F0},
        '{1'b1, 1'b1, 12'h000, 12'h0F0, 12'hF0F, 1'b0, 12'h123, 12'h456, 12'hF0F},
        '{1'b0, 1'b0, 12'h789, 12'h321, 12'h654, 1'b1, 12'h789, 12'h789, 12'h321},
        '{1'b0, 1'b1, 12'hABC, 12'h321, 12'h654, 1'b0, 12'hABC, 12'h789, 12'h654},
        '{1'b1, 1'b0, 12'hDEF, 12'h001, 12'h800, 1'b1, 12'hABC, 12'hDEF, 12'h001},
        '{1'b1, 1'b1, 12'h111, 12'h001, 12'h800, 1'b0, 12'hABC, 12'hDEF, 12'h800}
    };

    task automatic chk(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    initial begin
        #100000;
        errors++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        // Reset with every control active: R8 says they have no effect.
        cap1_n = 1'b0; cap2_n = 1'b0; a_in = 12'hFFF;
        oe_a_n = 1'b0; oe_b1_n = 1'b0; oe_b2_n = 1'b0;
        b1_in = 12'h777; pick_b1 = 1'b1;
        repeat (3) tick();
        chk("R8 b1_out in reset", b1_out, '0);
        chk("R8 b2_out in reset", b2_out, '0);
        chk("R8 a_out in reset", a_out, '0);
        chk("R8 drives in reset", {9'd0, a_drive, b1_drive, b2_drive}, '0);
        cap1_n = 1'b1; cap2_n = 1'b1;
        oe_a_n = 1'b1; oe_b1_n = 1'b1; oe_b2_n = 1'b1;
        rst = 1'b0;

        // Vector walk: R1 R2 R3 R4 R5.
        for (int i = 0; i < 8; i++) begin
            cap1_n  = TBL[i].c1n;
            cap2_n  = TBL[i].c2n;
            a_in    = TBL[i].a;
            b1_in   = TBL[i].b1;
            b2_in   = TBL[i].b2;
            pick_b1 = TBL[i].sel;
            tick();
            chk($sformatf("R1/R3 b1_out vec %0d", i), b1_out, TBL[i].exp_b1);
            chk($sformatf("R2/R3 b2_out vec %0d", i), b2_out, TBL[i].exp_b2);
            chk($sformatf("R5 a_out vec %0d", i), a_out, TBL[i].exp_a);
        end
        cap1_n = 1'b1; cap2_n = 1'b1;

        // R4: pack two words in sequence, then read both halves at once.
        cap1_n = 1'b0; a_in = 12'h5A5; tick();
        cap1_n = 1'b1; cap2_n = 1'b0; a_in = 12'hC3C; tick();
        cap2_n = 1'b1; a_in = 12'h000; tick();
        chk("R4 wide word", b1_out, 12'h5A5);
        chk("R4 wide word", b2_out, 12'hC3C);

        // R6: one-edge delay on the A enable.
        oe_a_n = 1'b0;
        #0.5;
        chk("R6 a_drive before edge", {11'd0, a_drive}, 12'd0);
        tick();
        chk("R6 a_drive after edge", {11'd0, a_drive}, 12'd1);
        chk("R7 b1 untouched by A enable", {11'd0, b1_drive}, 12'd0);
        chk("R7 b2 untouched by A enable", {11'd0, b2_drive}, 12'd0);

        oe_a_n = 1'b1; oe_b2_n = 1'b0;
        #0.5;
        chk("R6 a_drive held before edge", {11'd0, a_drive}, 12'd1);
        tick();
        chk("R6 a_drive off after edge", {11'd0, a_drive}, 12'd0);
        chk("R7 b2_drive on", {11'd0, b2_drive}, 12'd1);
        chk("R7 b1_drive still off", {11'd0, b1_drive}, 12'd0);

        oe_b1_n = 1'b0; tick();
        chk("R7 b1_drive on", {11'd0, b1_drive}, 12'd1);
        chk("R7 a_drive still off", {11'd0, a_drive}, 12'd0);

        // R8: reset in mid-run with enables low and a capture pending.
        oe_a_n = 1'b0; cap1_n = 1'b0; a_in = 12'h999;
        rst = 1'b1; tick();
        chk("R8 drives cleared", {9'd0, a_drive, b1_drive, b2_drive}, '0);
        chk("R8 b1_out cleared", b1_out, '0);
        chk("R8 b2_out cleared", b2_out, '0);
        chk("R8 a_out cleared", a_out, '0);
        tick();
        chk("R8 held reset ignores enables", {9'd0, a_drive, b1_drive, b2_drive}, '0);
        chk("R8 held reset ignores capture", b1_out, '0);
        rst = 1'b0; tick();
        chk("R6 drives return after reset", {9'd0, a_drive, b1_drive, b2_drive}, 12'h007);
        chk("R1 capture after reset", b1_out, 12'h999);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule